// File: doc/BRIEF.md
# Shared LFSR Multi-Port View Generator

This block holds one 32-bit linear feedback shift register that steps on every clock and hands out pseudo-random values to a set of client ports. Each port sees its own 32-bit view of the shared state. The view is made by moving every state bit to a new position and then inverting a fixed subset of bits. Both the bit move and the inversion pattern depend on the port number, so clients that read in the same cycle get unrelated-looking words from one register.

Each port has a continuous view output and a small read interface. A read either returns the whole view word with a destination write strobe, or returns one pseudo-random bit towards a carry flag, a zero flag or both. In the single-bit case the destination write strobe stays low, so the client's destination is left untouched.

Requests are accepted in every cycle. A response is valid exactly one cycle after its request. The interface is valid-only and has no ready signal. The value is time-varying, so holding it back would only return a stale sample; a client that must hold a response registers it itself.

Top module: `lfsr_views_top`

## Requirements
- R1: In the first cycle after synchronous reset (`rst` high, active-high) is released, the state equals the parameter `SEED`. Every port's view then equals its mapping of `SEED`. A zero `SEED` is replaced by 1.
- R2: The state steps once on every clock edge outside reset, whether or not any port reads. The step is next = {s[30:0], s[31]^s[21]^s[1]^s[0]}, which is a maximal-length polynomial with period 2^32-1.
- R3: The state is never all zeros. At the ports, a view never equals that port's inversion mask.
- R4: Bit i of port p's view is state[(m*i + o) mod 32] XOR mask[i]. Here m = 2p+3, o = (7p+1) mod 32, and mask = 32'h5A3CC3A5 rotated left by (3p+1) mod 32.
- R5: A response on port p is valid exactly one cycle after `req_valid[p]`. It carries the view from the cycle in which the request was made.
- R6: Operation code 2'b00 (word read) sets `rsp_dst_we`, returns the view on `rsp_data`, and keeps both flag strobes low.
- R7: Operation code 2'b01 (carry read) puts view bit 31 on `rsp_c`, sets `rsp_c_we`, keeps `rsp_dst_we` and `rsp_z_we` low, and drives `rsp_data` to zero.
- R8: Operation code 2'b10 puts view bit 31 on `rsp_z` with `rsp_z_we` set. Operation code 2'b11 sets both flag strobes with bit 31 on both flags. Neither code writes the destination.
- R9: Without a request, including during reset, the response valid and all write strobes of that port are low in the following cycle.
- R10: Several ports that request in the same cycle are each answered with their own view, in the same response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads the seed |
| req_valid | input | N | Read request per port |
| req_op | input | 2*N | Operation code per port, port p at bits [2p+1:2p] |
| view_out | output | 32*N | Continuous view per port, port p at bits [32p+31:32p] |
| rsp_valid | output | N | Response valid per port |
| rsp_data | output | 32*N | Word read result per port |
| rsp_dst_we | output | N | Destination write strobe |
| rsp_c | output | N | Pseudo-random bit for the carry flag |
| rsp_c_we | output | N | Carry flag write strobe |
| rsp_z | output | N | Pseudo-random bit for the zero flag |
| rsp_z_we | output | N | Zero flag write strobe |

## Verification
The bench builds the block with its defaults: N = 8 ports and a non-zero seed of 32'h1D872B41. With eight ports, the multipliers 3 through 17 and mask rotations 1 through 22 are all in use, so every position formula of R4 is compared against an independent software model in every cycle of a free run of several thousand steps. All four operation codes are driven on the first and last port and on a middle port, and a cycle with every port requesting at once reaches the same-cycle case of R10.

// File: rtl/lfsr_views_pkg.sv
package lfsr_views_pkg;

  localparam int STATE_W  = 32;
  localparam int BIT_SEL  = STATE_W - 1;
  localparam logic [STATE_W-1:0] MASK_BASE = 32'h5A3C_C3A5;

  typedef enum logic [1:0] {
    OP_WORD  = 2'b00,
    OP_CARRY = 2'b01,
    OP_ZERO  = 2'b10,
    OP_BOTH  = 2'b11
  } rd_op_e;

  function automatic logic [STATE_W-1:0] lfsr_step(input logic [STATE_W-1:0] s);
    logic fb;
    fb = s[31] ^ s[21] ^ s[1] ^ s[0];
    return {s[STATE_W-2:0], fb};
  endfunction

  function automatic int perm_src(input int port, input int bit_i);
    return ((2 * port + 3) * bit_i + 7 * port + 1) % STATE_W;
  endfunction

  function automatic logic [STATE_W-1:0] inv_mask(input int port);
    int amt;
    amt = (3 * port + 1) % STATE_W;
    if (amt == 0) return MASK_BASE;
    return (MASK_BASE << amt) | (MASK_BASE >> (STATE_W - amt));
  endfunction

endpackage

// File: rtl/lfsr_core.sv
module lfsr_core
  import lfsr_views_pkg::*;
#(
  parameter logic [STATE_W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic               clk,
  input  logic               rst,
  output logic [STATE_W-1:0] state
);

  localparam logic [STATE_W-1:0] SEED_EFF = (SEED == '0) ? STATE_W'(1) : SEED;

  logic [STATE_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED_EFF;
    else     state_q <= lfsr_step(state_q);
  end

  assign state = state_q;

endmodule

// File: rtl/view_map.sv
module view_map
  import lfsr_views_pkg::*;
#(
  parameter int PORT = 0
) (
  input  logic [STATE_W-1:0] state,
  output logic [STATE_W-1:0] view
);

  localparam logic [STATE_W-1:0] MASK = inv_mask(PORT);

  for (genvar i = 0; i < STATE_W; i++) begin : g_bit
    localparam int SRC = perm_src(PORT, i);
    assign view[i] = state[SRC] ^ MASK[i];
  end

endmodule

// File: rtl/port_reader.sv
module port_reader
  import lfsr_views_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [STATE_W-1:0] view,
  output logic               rsp_valid,
  output logic [STATE_W-1:0] rsp_data,
  output logic               rsp_dst_we,
  output logic               rsp_c,
  output logic               rsp_c_we,
  output logic               rsp_z,
  output logic               rsp_z_we
);

  logic [STATE_W-1:0] data_d;
  logic               dst_we_d, c_we_d, z_we_d, bit_d;

  assign bit_d = view[BIT_SEL];

  always_comb begin
    data_d   = '0;
    dst_we_d = 1'b0;
    c_we_d   = 1'b0;
    z_we_d   = 1'b0;
    if (req_valid) begin
      unique case (rd_op_e'(req_op))
        OP_WORD: begin
          data_d   = view;
          dst_we_d = 1'b1;
        end
        OP_CARRY: c_we_d = 1'b1;
        OP_ZERO:  z_we_d = 1'b1;
        OP_BOTH: begin
          c_we_d = 1'b1;
          z_we_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_dst_we <= 1'b0;
      rsp_c      <= 1'b0;
      rsp_c_we   <= 1'b0;
      rsp_z      <= 1'b0;
      rsp_z_we   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_data   <= data_d;
      rsp_dst_we <= dst_we_d;
      rsp_c      <= c_we_d & bit_d;
      rsp_c_we   <= c_we_d;
      rsp_z      <= z_we_d & bit_d;
      rsp_z_we   <= z_we_d;
    end
  end

endmodule

// File: rtl/lfsr_views_top.sv
module lfsr_views_top
  import lfsr_views_pkg::*;
#(
  parameter int                 N    = 8,
  parameter logic [STATE_W-1:0] SEED = 32'h1D87_2B41
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req_valid,
  input  logic [2*N-1:0]       req_op,
  output logic [STATE_W*N-1:0] view_out,
  output logic [N-1:0]         rsp_valid,
  output logic [STATE_W*N-1:0] rsp_data,
  output logic [N-1:0]         rsp_dst_we,
  output logic [N-1:0]         rsp_c,
  output logic [N-1:0]         rsp_c_we,
  output logic [N-1:0]         rsp_z,
  output logic [N-1:0]         rsp_z_we
);

  logic [STATE_W-1:0] state;

  lfsr_core #(.SEED(SEED)) u_core (
    .clk   (clk),
    .rst   (rst),
    .state (state)
  );

  for (genvar p = 0; p < N; p++) begin : g_port
    logic [STATE_W-1:0] view;

    view_map #(.PORT(p)) u_map (
      .state (state),
      .view  (view)
    );

    port_reader u_rd (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid[p]),
      .req_op     (req_op[2*p +: 2]),
      .view       (view),
      .rsp_valid  (rsp_valid[p]),
      .rsp_data   (rsp_data[STATE_W*p +: STATE_W]),
      .rsp_dst_we (rsp_dst_we[p]),
      .rsp_c      (rsp_c[p]),
      .rsp_c_we   (rsp_c_we[p]),
      .rsp_z      (rsp_z[p]),
      .rsp_z_we   (rsp_z_we[p])
    );

    assign view_out[STATE_W*p +: STATE_W] = view;
  end

endmodule

// File: rtl/lfsr_views_chk.sv
module lfsr_views_chk
  import lfsr_views_pkg::*;
#(
  parameter int                 N    = 8,
  parameter logic [STATE_W-1:0] SEED = 32'h1D87_2B41
) (
  input logic               clk,
  input logic               rst,
  input logic [STATE_W-1:0] state,
  input logic [N-1:0]       req_valid,
  input logic [2*N-1:0]     req_op,
  input logic [N-1:0]       rsp_valid,
  input logic [N-1:0]       rsp_dst_we,
  input logic [N-1:0]       rsp_c_we,
  input logic [N-1:0]       rsp_z_we
);

  localparam logic [STATE_W-1:0] SEED_EFF = (SEED == '0) ? STATE_W'(1) : SEED;

  logic was_rst;
  always_ff @(posedge clk) begin
    was_rst <= rst;
    // R1
    if (was_rst === 1'b1 && rst === 1'b0)
      seed_load_chk: assert (state == SEED_EFF);
  end

  // R3
  state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R2
  state_moves_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> state != $past(state));

  for (genvar p = 0; p < N; p++) begin : g_p
    // R5
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid[p] |=> rsp_valid[p]);
    // R9
    no_req_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
      !req_valid[p] |=> !rsp_valid[p]);
    // R9
    idle_strobes_chk: assert property (@(posedge clk) disable iff (rst)
      !rsp_valid[p] |-> !(rsp_dst_we[p] || rsp_c_we[p] || rsp_z_we[p]));
    // R6
    word_no_flags_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_dst_we[p] |-> !rsp_c_we[p] && !rsp_z_we[p]);
    // R7
    flag_keeps_dst_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid[p] && req_op[2*p +: 2] != 2'b00) |=> !rsp_dst_we[p]);
  end

endmodule

bind lfsr_views_top lfsr_views_chk #(.N(N), .SEED(SEED)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .state      (state),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .rsp_valid  (rsp_valid),
  .rsp_dst_we (rsp_dst_we),
  .rsp_c_we   (rsp_c_we),
  .rsp_z_we   (rsp_z_we)
);

// File: tb/test_lfsr_views_top.sv
module test_lfsr_views_top;

  localparam int          N    = 8;
  localparam logic [31:0] SEED = 32'h1D87_2B41;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [32*N-1:0] view_out, rsp_data;
  logic [N-1:0]    rsp_valid, rsp_dst_we, rsp_c, rsp_c_we, rsp_z, rsp_z_we;

  int checks = 0;
  int errors = 0;
  logic [31:0] m;

  always #10 clk = ~clk;

  lfsr_views_top #(.N(N), .SEED(SEED)) i_lfsr_views_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .view_out(view_out), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_dst_we(rsp_dst_we), .rsp_c(rsp_c), .rsp_c_we(rsp_c_we),
    .rsp_z(rsp_z), .rsp_z_we(rsp_z_we)
  );

  function automatic logic [31:0] m_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] m_mask(input int p);
    logic [31:0] b = 32'h5A3C_C3A5;
    int a = (3 * p + 1) % 32;
    return (a == 0) ? b : ((b << a) | (b >> (32 - a)));
  endfunction

  function automatic logic [31:0] m_view(input int p, input logic [31:0] s);
    logic [31:0] v;
    logic [31:0] mk = m_mask(p);
    for (int i = 0; i < 32; i++) v[i] = s[((2 * p + 3) * i + 7 * p + 1) % 32] ^ mk[i];
    return v;
  endfunction

  // reference model of R2 stepping
  always @(posedge clk) m <= rst ? SEED : m_step(m);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    req_valid = '1;
    tick();
    tick();
    check("R9 reset rsp_valid", 32'(rsp_valid), 32'h0);
    check("R9 reset dst_we", 32'(rsp_dst_we | rsp_c_we | rsp_z_we), 32'h0);
    req_valid = '0;
    rst = 1'b0;
    for (int p = 0; p < N; p++)
      check("R1 seed view", view_out[32*p +: 32], m_view(p, SEED));
  endtask

  task automatic t_free_run(input int n, input bit with_reads);
    for (int c = 0; c < n; c++) begin
      req_valid = with_reads ? N'(c * 37) : '0;
      req_op = 16'(c * 13);
      for (int p = 0; p < N; p++) begin
        check("R4 view vs model", view_out[32*p +: 32], m_view(p, m));
        if (view_out[32*p +: 32] === m_mask(p)) check("R3 zero state seen", 32'h1, 32'h0);
      end
      tick();
    end
    req_valid = '0;
    check("R2 steps independent of reads", view_out[31:0], m_view(0, m));
  endtask

  task automatic t_read(input int p, input logic [1:0] op);
    logic [31:0] ev;
    logic b;
    ev = m_view(p, m);
    b = ev[31];
    req_valid[p] = 1'b1;
    req_op[2*p +: 2] = op;
    tick();
    req_valid[p] = 1'b0;
    check("R5 rsp_valid", 32'(rsp_valid[p]), 32'h1);
    case (op)
      2'b00: begin
        check("R6 word data", rsp_data[32*p +: 32], ev);
        check("R6 strobes dst/c/z", {29'h0, rsp_dst_we[p], rsp_c_we[p], rsp_z_we[p]}, 32'h4);
      end
      2'b01: begin
        check("R7 carry bit", 32'(rsp_c[p]), 32'(b));
        check("R7 strobes dst/c/z", {29'h0, rsp_dst_we[p], rsp_c_we[p], rsp_z_we[p]}, 32'h2);
        check("R7 data zero", rsp_data[32*p +: 32], 32'h0);
      end
      2'b10: begin
        check("R8 zero bit", 32'(rsp_z[p]), 32'(b));
        check("R8 strobes dst/c/z", {29'h0, rsp_dst_we[p], rsp_c_we[p], rsp_z_we[p]}, 32'h1);
      end
      default: begin
        check("R8 both bits", {30'h0, rsp_c[p], rsp_z[p]}, {30'h0, b, b});
        check("R8 both strobes dst/c/z", {29'h0, rsp_dst_we[p], rsp_c_we[p], rsp_z_we[p]}, 32'h3);
      end
    endcase
    tick();
    check("R9 no request rsp_valid", 32'(rsp_valid[p]), 32'h0);
    check("R9 no request strobes", {29'h0, rsp_dst_we[p], rsp_c_we[p], rsp_z_we[p]}, 32'h0);
  endtask

  task automatic t_all_ports();
    logic [31:0] ev [N];
    for (int p = 0; p < N; p++) ev[p] = m_view(p, m);
    req_valid = '1;
    req_op = '0;
    tick();
    req_valid = '0;
    check("R10 all valid", 32'(rsp_valid), 32'(N'('1)));
    for (int p = 0; p < N; p++)
      check("R10 own view per port", rsp_data[32*p +: 32], ev[p]);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_free_run(3000, 1'b0);
    t_free_run(3000, 1'b1);
    for (int op = 0; op < 4; op++) begin
      t_read(0, 2'(op));
      t_read(3, 2'(op));
      t_read(N - 1, 2'(op));
    end
    t_all_ports();
    t_reset();
    t_free_run(50, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule